// File: doc/BRIEF.md
# Multi-Device Configuration Download Controller

This block connects a host bus slave port to an 8-bit on-card data bus shared by sixteen reprogrammable logic devices. The host loads a device by writing bytes, one after another, to that device's configuration address. Each byte goes out on the shared bus with a one-clock write strobe aimed at that device. The host acknowledge is then held back until the device reports ready. The same bus carries monitoring data back from any device, one byte per read. A ready/busy probe reads one device's ready line. A packed status word reports the completion flag of every device at once.

Devices may be loaded in any order and stay dormant after loading. A single write to the start register releases all of them on the same clock edge. Two sticky flags record trouble. The timeout flag is set when a device stays busy for too long, and a start write clears it. The premature flag is set when a start is issued while some device is not yet complete, and only reset clears it.

The host port follows valid/ready rules. The host raises `hst_valid` with a stable `hst_write`, `hst_addr` and `hst_wdata`. It keeps them unchanged until it sees `hst_ready` high at a rising edge, which completes the transfer. `hst_rdata` is meaningful only in that cycle. After a completed transfer the host drops `hst_valid`, or presents a new request, on the next cycle. The controller handles one request at a time, and back-pressure is simply `hst_ready` held low.

Top module: `cfg_download_ctrl`

## Requirements
- R1: Address map. Bits [7:4] select device d (0 to 15). When bits [3:2] are 0, bits [1:0] select the function: 0 is configuration write, 1 is ready read, 2 is monitor read. Register offsets, all in device field 0: 0x04 is completion status (read), 0x08 is start (write), 0x0C is flags (read).
- R2: The clock after a configuration write to device d is accepted, `dev_wr_stb` equals exactly bit d for one clock and `dev_bus_out` carries `hst_wdata`. The bus stays driven (`dev_bus_oe` high) from that strobe cycle through the acknowledge cycle.
- R3: After the strobe, `hst_ready` stays low while `dev_rdy[d]` is low. It is high in the first following cycle in which `dev_rdy[d]` is high, including the very first one.
- R4: If `dev_rdy[d]` is still low in the 1024th cycle after the strobe (TIMEOUT), that cycle acknowledges anyway. `err_timeout` then reads high from the next cycle on. Ready arriving in that same cycle acknowledges without setting the flag.
- R5: A ready read of device d acknowledges one cycle after acceptance. `hst_rdata` bit 0 is `dev_rdy[d]` as sampled at acceptance, and all other bits are zero.
- R6: A monitor read of device d raises `dev_rd_stb` bit d for one clock with the bus released. The acknowledge follows one cycle later, and `hst_rdata[7:0]` holds `dev_bus_in` as seen during the strobe cycle.
- R7: A read of the completion status returns `dev_done`, bit d for device d, one cycle after acceptance.
- R8: A start write raises `dev_start` for exactly one clock, in the cycle after acceptance (also the acknowledge cycle). In that same cycle `err_timeout` is already clear.
- R9: A start accepted while any bit of `dev_done` is low still pulses `dev_start`. It also sets `err_premature`, which stays high until reset.
- R10: Writes to non-writable or unmapped addresses are acknowledged one cycle after acceptance and cause no strobe, no start and no flag change. Reads of unmapped or write-only addresses return zero. A flags read returns bit 0 = timeout and bit 1 = premature.
- R11: During and just after reset, `hst_ready`, all strobes, `dev_start`, `dev_bus_oe` and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host request valid |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Host address |
| hst_wdata | input | 8 | Host write byte |
| hst_ready | output | 1 | Request completed (acknowledge) |
| hst_rdata | output | 16 | Read data, valid with `hst_ready` |
| dev_bus_out | output | 8 | Byte driven onto the shared bus |
| dev_bus_oe | output | 1 | Shared bus driven by the controller |
| dev_bus_in | input | 8 | Byte read from the shared bus |
| dev_wr_stb | output | 16 | Per-device configuration write strobe |
| dev_rd_stb | output | 16 | Per-device monitor read strobe |
| dev_rdy | input | 16 | Per-device ready (1) / busy (0) |
| dev_done | input | 16 | Per-device completion flag |
| dev_start | output | 1 | Global release pulse |
| err_timeout | output | 1 | Sticky busy-timeout flag |
| err_premature | output | 1 | Sticky early-start flag |

## Verification
Two pairs of events can fall into the same cycle. In the first, a device's ready line rises in the very cycle in which the busy timeout expires. The bench holds a device busy for exactly 1023 wait cycles and judges that the acknowledge lands there with the timeout flag left clear. A device held busy past the limit must instead set it. In the second, a start write meets a completion word that is not yet full. The bench changes `dev_done` just before the start request and expects the release pulse, the acknowledge, the timeout flag clearing and the premature flag rising all in the one cycle after acceptance.

// File: rtl/cfgdl_pkg.sv
package cfgdl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STROBE, ST_WAIT, ST_MON, ST_ACK
  } cfgdl_st_e;

  typedef enum logic [2:0] {
    OP_CFG, OP_RDY, OP_MON, OP_DONE, OP_START, OP_FLAGS, OP_NONE
  } cfgdl_op_e;

  localparam logic [3:0] OFS_DONE  = 4'h4;
  localparam logic [3:0] OFS_START = 4'h8;
  localparam logic [3:0] OFS_FLAGS = 4'hC;
endpackage

// File: rtl/cfgdl_decode.sv
module cfgdl_decode
  import cfgdl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_DEV  = 16,
  localparam int DEV_W = $clog2(N_DEV)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output cfgdl_op_e         op,
  output logic [DEV_W-1:0]  dev
);
  logic [3:0] low;
  assign low = addr[3:0];
  assign dev = addr[ADDR_W-1 -: DEV_W];

  always_comb begin
    op = OP_NONE;
    if (low[3:2] == 2'b00) begin
      case (low[1:0])
        2'd0:    op = write ? OP_CFG : OP_NONE;
        2'd1:    op = write ? OP_NONE : OP_RDY;
        2'd2:    op = write ? OP_NONE : OP_MON;
        default: op = OP_NONE;
      endcase
    end else if (dev == '0) begin
      if (low == OFS_DONE && !write)  op = OP_DONE;
      if (low == OFS_START && write)  op = OP_START;
      if (low == OFS_FLAGS && !write) op = OP_FLAGS;
    end
  end
endmodule

// File: rtl/cfgdl_timer.sv
module cfgdl_timer #(
  parameter int LIMIT = 1024,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/cfgdl_onehot.sv
module cfgdl_onehot #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     vec
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/cfg_download_ctrl.sv
module cfg_download_ctrl
  import cfgdl_pkg::*;
#(
  parameter int N_DEV   = 16,
  parameter int ADDR_W  = 8,
  parameter int BUS_W   = 8,
  parameter int TIMEOUT = 1024,
  localparam int DEV_W  = $clog2(N_DEV),
  localparam int RD_W   = N_DEV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [BUS_W-1:0]  hst_wdata,
  output logic              hst_ready,
  output logic [RD_W-1:0]   hst_rdata,
  output logic [BUS_W-1:0]  dev_bus_out,
  output logic              dev_bus_oe,
  input  logic [BUS_W-1:0]  dev_bus_in,
  output logic [N_DEV-1:0]  dev_wr_stb,
  output logic [N_DEV-1:0]  dev_rd_stb,
  input  logic [N_DEV-1:0]  dev_rdy,
  input  logic [N_DEV-1:0]  dev_done,
  output logic              dev_start,
  output logic              err_timeout,
  output logic              err_premature
);
  cfgdl_st_e        st;
  cfgdl_op_e        op;
  logic [DEV_W-1:0] dev_idx, sel_q;
  logic [BUS_W-1:0] data_q;
  logic [RD_W-1:0]  rdata_q;
  logic             start_q, to_q, pm_q, tmr_expired, cur_rdy;

  cfgdl_decode #(.ADDR_W(ADDR_W), .N_DEV(N_DEV)) u_dec (
    .addr(hst_addr), .write(hst_write), .op(op), .dev(dev_idx)
  );

  cfgdl_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == ST_WAIT), .expired(tmr_expired)
  );

  cfgdl_onehot #(.N(N_DEV)) u_wr_sel (
    .en(st == ST_STROBE), .idx(sel_q), .vec(dev_wr_stb)
  );

  cfgdl_onehot #(.N(N_DEV)) u_rd_sel (
    .en(st == ST_MON), .idx(sel_q), .vec(dev_rd_stb)
  );

  assign cur_rdy = dev_rdy[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sel_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      start_q <= 1'b0;
      to_q    <= 1'b0;
      pm_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        ST_IDLE: if (hst_valid) begin
          sel_q   <= dev_idx;
          rdata_q <= '0;
          st      <= ST_ACK;
          case (op)
            OP_CFG: begin
              data_q <= hst_wdata;
              st     <= ST_STROBE;
            end
            OP_RDY:   rdata_q <= RD_W'(dev_rdy[dev_idx]);
            OP_MON:   st <= ST_MON;
            OP_DONE:  rdata_q <= RD_W'(dev_done);
            OP_FLAGS: rdata_q <= RD_W'({pm_q, to_q});
            OP_START: begin
              start_q <= 1'b1;
              to_q    <= 1'b0;
              if (!(&dev_done)) pm_q <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_STROBE: st <= ST_WAIT;
        ST_WAIT: begin
          if (cur_rdy) st <= ST_IDLE;
          else if (tmr_expired) begin
            to_q <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_MON: begin
          rdata_q <= RD_W'(dev_bus_in);
          st      <= ST_ACK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign hst_ready     = (st == ST_ACK) || (st == ST_WAIT && (cur_rdy || tmr_expired));
  assign hst_rdata     = rdata_q;
  assign dev_bus_out   = data_q;
  assign dev_bus_oe    = (st == ST_STROBE) || (st == ST_WAIT);
  assign dev_start     = start_q;
  assign err_timeout   = to_q;
  assign err_premature = pm_q;

  // R2: a write strobe drives the bus and never meets a read strobe
  a_r2_strobe_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_wr_stb) |-> (dev_bus_oe && !(|dev_rd_stb)));

  // R2: a write strobe lasts one clock
  a_r2_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_wr_stb) |=> !(|dev_wr_stb));

  // R3/R4: acknowledging a busy device implies the timeout flag afterwards
  a_r4_busy_ack_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && hst_ready && !cur_rdy) |=> err_timeout);

  // R4: an expired wait always ends the transfer
  a_r4_expiry_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && tmr_expired) |=> (st == ST_IDLE));

  // R6: monitor strobe never overlaps a driven bus
  a_r6_mon_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_rd_stb) |-> !dev_bus_oe);

  // R8: start pulse is a single clock and the timeout flag is clear with it
  a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    dev_start |=> !dev_start);
  a_r8_start_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    dev_start |-> !err_timeout);

  // R9: premature flag is sticky
  a_r9_premature_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_premature |=> err_premature);
endmodule

// File: tb/cfg_download_ctrl_tb.sv
module cfg_download_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0;
  logic [7:0]  hst_addr = '0, hst_wdata = '0;
  logic        hst_ready;
  logic [15:0] hst_rdata;
  logic [7:0]  dev_bus_out, dev_bus_in;
  logic        dev_bus_oe;
  logic [15:0] dev_wr_stb, dev_rd_stb;
  logic [15:0] dev_rdy = 16'hFFFF, dev_done = 16'h0000;
  logic        dev_start, err_timeout, err_premature;

  int n_cmp = 0, n_bad = 0;
  bit exp_to = 0, exp_pm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_download_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_ready(hst_ready),
    .hst_rdata(hst_rdata), .dev_bus_out(dev_bus_out), .dev_bus_oe(dev_bus_oe),
    .dev_bus_in(dev_bus_in), .dev_wr_stb(dev_wr_stb), .dev_rd_stb(dev_rd_stb),
    .dev_rdy(dev_rdy), .dev_done(dev_done), .dev_start(dev_start),
    .err_timeout(err_timeout), .err_premature(err_premature)
  );

  function automatic logic [7:0] mon_val(int i);
    return 8'(8'hA5 ^ (i * 7));
  endfunction

  // device model: a selected device places its monitor byte on the bus
  always_comb begin
    dev_bus_in = 8'h00;
    for (int i = 0; i < 16; i++)
      if (dev_rd_stb[i]) dev_bus_in = mon_val(i);
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare one cycle (inputs already set), then move to next negedge
  task automatic step(bit e_rdy, logic [15:0] e_wstb, logic [15:0] e_rstb,
                      bit e_start, bit e_oe, logic [7:0] e_bus, int e_rdata, string tag);
    #1;
    cmp({tag, " ready"}, int'(hst_ready), int'(e_rdy));
    cmp({tag, " wr_stb"}, int'(dev_wr_stb), int'(e_wstb));
    cmp({tag, " rd_stb"}, int'(dev_rd_stb), int'(e_rstb));
    cmp({tag, " start"}, int'(dev_start), int'(e_start));
    cmp({tag, " oe"}, int'(dev_bus_oe), int'(e_oe));
    if (e_oe) cmp({tag, " bus"}, int'(dev_bus_out), int'(e_bus));
    if (e_rdy && e_rdata >= 0) cmp({tag, " rdata"}, int'(hst_rdata), e_rdata);
    cmp({tag, " timeout flag"}, int'(err_timeout), int'(exp_to));
    cmp({tag, " premature flag"}, int'(err_premature), int'(exp_pm));
    @(negedge clk);
  endtask

  task automatic req(bit w, logic [7:0] a, logic [7:0] d);
    hst_valid = 1'b1; hst_write = w; hst_addr = a; hst_wdata = d;
  endtask

  task automatic idle(string tag);
    hst_valid = 1'b0;
    step(0, 0, 0, 0, 0, 0, -1, tag);
  endtask

  // configuration write with a device busy for 'busy' wait cycles
  task automatic cfg_wr(int d, logic [7:0] b, int busy, string tag);
    req(1, 8'(d * 16), b);
    step(0, 0, 0, 0, 0, 0, -1, {tag, " R1 accept"});
    step(0, 16'(1 << d), 0, 0, 1, b, -1, {tag, " R2 strobe"});
    for (int k = 0; k < TO + 8; k++) begin
      bit r, rd;
      r = (k >= busy);
      dev_rdy[d] = r;
      rd = r || (k == TO - 1);
      step(rd, 0, 0, 0, 1, b, -1, {tag, " R3 wait"});
      if (rd) begin
        if (!r) exp_to = 1;  // R4 flag visible from next cycle
        break;
      end
    end
    dev_rdy[d] = 1'b1;
    idle({tag, " R3 release"});
  endtask

  // single-cycle-ack request
  task automatic simple(bit w, logic [7:0] a, int e_rdata, bit is_start, string tag);
    req(w, a, 8'h3C);
    step(0, 0, 0, 0, 0, 0, -1, {tag, " accept"});
    if (is_start) begin
      exp_to = 0;
      if (dev_done != 16'hFFFF) exp_pm = 1;
    end
    step(1, 0, 0, is_start, 0, 0, e_rdata, {tag, " ack"});
    idle({tag, " after"});
  endtask

  task automatic mon_rd(int d, string tag);
    req(0, 8'(d * 16 + 2), 8'h00);
    step(0, 0, 0, 0, 0, 0, -1, {tag, " R6 accept"});
    step(0, 0, 16'(1 << d), 0, 0, 0, -1, {tag, " R6 strobe"});
    step(1, 0, 0, 0, 0, 0, int'(mon_val(d)), {tag, " R6 ack"});
    idle({tag, " R6 after"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    cmp("R11 reset ready", int'(hst_ready), 0);
    cmp("R11 reset oe", int'(dev_bus_oe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R11 after reset");
    idle("R11 idle");

    simple(0, 8'h0C, 0, 0, "R10 flags clear");
    simple(0, 8'h04, 16'h0000, 0, "R7 done empty");

    cfg_wr(0, 8'h5A, 0, "R3 ready at once");
    cfg_wr(15, 8'hC3, 3, "R3 busy three");
    cfg_wr(7, 8'h81, TO - 1, "R4 ready at limit");

    dev_rdy[7] = 1'b0;
    simple(0, 8'h71, 0, 0, "R5 busy read");
    dev_rdy[7] = 1'b1;
    simple(0, 8'h71, 1, 0, "R5 ready read");

    mon_rd(3, "mon3");
    mon_rd(12, "mon12");

    simple(1, 8'h21, -1, 0, "R10 write ready addr");
    simple(1, 8'h04, -1, 0, "R10 write done reg");
    simple(0, 8'h33, 0, 0, "R10 unmapped read");
    simple(0, 8'h50, 0, 0, "R10 cfg addr read");
    simple(0, 8'h08, 0, 0, "R10 start read");
    simple(0, 8'h0C, 0, 0, "R10 flags still clear");

    dev_done = 16'h7FFF;
    simple(0, 8'h04, 16'h7FFF, 0, "R7 done partial");
    simple(1, 8'h08, -1, 1, "R9 premature start");
    simple(0, 8'h0C, 2, 0, "R9 flags premature");

    cfg_wr(5, 8'h11, TO + 5, "R4 timeout");
    simple(0, 8'h0C, 3, 0, "R4 flags both");

    dev_done = 16'hFFFF;
    simple(1, 8'h08, -1, 1, "R8 start clears");
    simple(0, 8'h0C, 2, 0, "R8 R9 flags after start");
    simple(0, 8'h04, 16'hFFFF, 0, "R7 done full");
    cfg_wr(9, 8'hE7, 1, "R2 after start");
    idle("R11 final idle");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule